// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a page-aligned real address. It walks between one and five levels of translation tables held in memory. A root descriptor gives the origin of the top table and its kind: region-first, region-second, region-third or segment. From there the walk goes down through the lower region tables and the segment table, and ends at a page table. It can also end at a 1 MB large page when the caller has enabled large pages. Before each next fetch the walker checks the entry it has just read: the invalid flag, the type tag, and the offset and length window that limits the next index. Every kind of fault maps to its own exception class.

A request is presented with valid/ready. It carries the address, an access kind, the root descriptor, a 2-bit space identifier and the large-page enable. The request is taken only while the walker is idle; `req_ready` stays low until the result has been reported. Table entries are fetched through one 64-bit read port that uses two valid/ready channels, with at most one read outstanding. The read channel holds its address steady for as long as `mem_req_ready` is low. The response channel accepts data only while a read is pending, and the memory may delay its response for any number of cycles. A finished walk pulses `done` and presents the real address and the write permission. A failed walk pulses `exc` and presents a class code and a formatted exception code. Both results stay on their outputs until the next request ends.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `exc` and `mem_req_valid` are 0. `req_ready` is 1 only while idle, so it drops in the cycle after a request is accepted. `done` and `exc` never pulse together.
- R2: When root bit 5 (real-space) is set, the walk is skipped. The result is `done` with `real_addr` = {va[63:12], 12'h0}, and no table read is made.
- R3: Root bits [3:2] select the top level: 3 region-first, 2 region-second, 1 region-third, 0 segment. If va[63:53] is non-zero for a region-second root, va[63:42] for a region-third root, or va[63:31] for a segment root, the walk fails with class 1 (type).
- R4: The top two bits of the first index are compared with root length bits [1:0]. Those bits are va[63:62], va[52:51], va[41:40] or va[30:29], depending on the top level. If they are greater than the length, the walk fails with the class of the top level: 2 region-first, 3 region-second, 4 region-third, 5 segment.
- R5: The index fields are va[63:53], va[52:42], va[41:31] and va[30:20] for the region-first, region-second, region-third and segment tables, and va[19:12] for the page table. Each entry is read at table origin + index×8. Root and region origins are bits [63:12]; the page table origin of a segment entry is bits [63:11].
- R6: A region or segment entry with bit 5 set fails with the class of the level being read. An entry whose type bits [3:2] differ from that level's code fails with class 7 (specification).
- R7: A region entry limits the top two bits of the next index. Those bits must be no less than its offset field [7:6] and no greater than its length field [1:0]. Otherwise the walk fails with the class of the next level.
- R8: When `req_large` is 1 and a segment entry has bit 10 set, the walk ends without a page-table read, with `real_addr` = {entry[63:20], va[19:12], 12'h0}. When `req_large` is 0, bit 10 is ignored and the page table is read.
- R9: A page entry with bit 10 set fails with class 6 (page). A page entry with bit 11 set fails with class 7. Otherwise `real_addr` = {entry[63:12], 12'h0}.
- R10: Bit 9 of a segment entry or a page entry clears write permission. Bit 9 of a region entry clears it only when `req_large` is 1. `wr_ok` reports the write permission with `done`. A store (`req_acc` = 1) that finishes without write permission fails with class 8 (protection).
- R11: On a fault, `tec` = {va[63:12], 12'h0} OR 0x400 for a store (0x800 for any other access) OR the space id in bits [1:0]. It also ORs in 0x4 when the class is 8.
- R12: At most one table read is outstanding. `mem_req_valid` and `mem_rsp_ready` are never high together. `mem_addr` stays stable and 8-byte aligned while a read request stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 data read, 1 store, 2 instruction fetch |
| req_root | input | 64 | Root descriptor |
| req_sid | input | 2 | Space identifier placed in the exception code |
| req_large | input | 1 | Large-page enable |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_addr | output | 64 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 64 | Table entry |
| done | output | 1 | One-cycle pulse: translation finished |
| real_addr | output | 64 | Page-aligned real address |
| wr_ok | output | 1 | Write permission of the finished translation |
| exc | output | 1 | One-cycle pulse: translation faulted |
| exc_class | output | 4 | Fault class code |
| tec | output | 64 | Formatted exception code |

## Verification
The block has no tunable parameters: the field widths are fixed by the table format. The bench therefore builds it as it is. The bench's own memory model drops `mem_req_ready` at random and delays read data by zero to two cycles. This exercises stalled read requests and late responses at every level of the walk. Random table chains run from all four root kinds, with sparse corruption of the invalid, type, offset, length, read-only, large-page and reserved bits. These chains reach the fault paths at each depth. Directed cases pin each fault class, the large-page early exit and the region read-only rule to exact read counts.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int VA_W  = 64;
  localparam int ENT_W = 64;
  localparam int IDX_W = 11;
  localparam int PIX_W = 8;
  localparam int CLS_W = 4;
  localparam int OFS_W = IDX_W + 3;

  typedef enum logic [2:0] {
    LV_SEG  = 3'd0,
    LV_R3   = 3'd1,
    LV_R2   = 3'd2,
    LV_R1   = 3'd3,
    LV_PAGE = 3'd4
  } lvl_e;

  typedef enum logic [CLS_W-1:0] {
    XC_NONE = 4'd0,
    XC_TYPE = 4'd1,
    XC_R1   = 4'd2,
    XC_R2   = 4'd3,
    XC_R3   = 4'd4,
    XC_SEG  = 4'd5,
    XC_PAGE = 4'd6,
    XC_SPEC = 4'd7,
    XC_PROT = 4'd8
  } xcls_e;

  localparam logic [1:0] ACC_STORE = 2'd1;

  function automatic xcls_e trans_cls(input lvl_e l);
    case (l)
      LV_R1:   return XC_R1;
      LV_R2:   return XC_R2;
      LV_R3:   return XC_R3;
      LV_SEG:  return XC_SEG;
      default: return XC_PAGE;
    endcase
  endfunction

  function automatic logic [1:0] top2(input logic [VA_W-1:0] va, input lvl_e l);
    case (l)
      LV_R1:   return va[63:62];
      LV_R2:   return va[52:51];
      LV_R3:   return va[41:40];
      LV_SEG:  return va[30:29];
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pt_root_check.sv
module pt_root_check
  import pt_walker_pkg::*;
(
  input  logic [VA_W-1:0]  va,
  input  logic [ENT_W-1:0] root,
  output logic             real_sp,
  output lvl_e             top_lvl,
  output xcls_e            cls,
  output logic [VA_W-1:0]  origin
);
  logic range_bad;
  logic unused_root;

  assign real_sp = root[5];
  assign top_lvl = lvl_e'({1'b0, root[3:2]});
  assign origin  = {root[63:12], 12'h0};
  assign unused_root = ^{root[11:6], root[4], va[28:0]};

  always_comb begin
    case (top_lvl)
      LV_R2:   range_bad = |va[63:53];
      LV_R3:   range_bad = |va[63:42];
      LV_SEG:  range_bad = |va[63:31];
      default: range_bad = 1'b0;
    endcase
  end

  always_comb begin
    cls = XC_NONE;
    if (range_bad)
      cls = XC_TYPE;
    else if (top2(va, top_lvl) > root[1:0])
      cls = trans_cls(top_lvl);
  end
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walker_pkg::*;
(
  input  lvl_e             lvl,
  input  logic [ENT_W-1:0] ent,
  input  logic [VA_W-1:0]  va,
  input  logic             large_en,
  output xcls_e            cls,
  output logic             leaf,
  output logic             ro,
  output lvl_e             nxt_lvl,
  output logic [VA_W-1:0]  nxt_org,
  output logic [VA_W-1:0]  leaf_ra
);
  lvl_e       below;
  logic [1:0] nidx;
  logic       unused_dec;

  assign below = lvl_e'(lvl - 3'd1);
  assign nidx  = top2(va, below);
  assign unused_dec = ^{ent[8], ent[4], va[11:0]};

  always_comb begin
    cls     = XC_NONE;
    leaf    = 1'b0;
    ro      = 1'b0;
    nxt_lvl = lvl;
    nxt_org = '0;
    leaf_ra = '0;
    if (lvl == LV_PAGE) begin
      if (ent[10])
        cls = XC_PAGE;
      else if (ent[11])
        cls = XC_SPEC;
      else begin
        leaf    = 1'b1;
        ro      = ent[9];
        leaf_ra = {ent[63:12], 12'h0};
      end
    end else if (ent[5]) begin
      cls = trans_cls(lvl);
    end else if (ent[3:2] != lvl[1:0]) begin
      cls = XC_SPEC;
    end else if (lvl == LV_SEG) begin
      ro = ent[9];
      if (ent[10] && large_en) begin
        leaf    = 1'b1;
        leaf_ra = {ent[63:20], va[19:12], 12'h0};
      end else begin
        nxt_lvl = LV_PAGE;
        nxt_org = {ent[63:11], 11'h0};
      end
    end else if (nidx < ent[7:6] || nidx > ent[1:0]) begin
      cls = trans_cls(below);
    end else begin
      ro      = large_en & ent[9];
      nxt_lvl = below;
      nxt_org = {ent[63:12], 12'h0};
    end
  end
endmodule

// File: rtl/pt_tec_fmt.sv
module pt_tec_fmt
  import pt_walker_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      acc,
  input  logic [1:0]      sid,
  input  logic            prot,
  output logic [VA_W-1:0] tec
);
  logic unused_low;
  assign unused_low = ^va[11:0];

  assign tec = {va[63:12], 12'h0}
             | ((acc == ACC_STORE) ? 64'h400 : 64'h800)
             | (prot ? 64'h4 : 64'h0)
             | {{(VA_W-2){1'b0}}, sid};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  input  logic [ENT_W-1:0] req_root,
  input  logic [1:0]       req_sid,
  input  logic             req_large,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [VA_W-1:0]  mem_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [VA_W-1:0]  real_addr,
  output logic             wr_ok,
  output logic             exc,
  output logic [CLS_W-1:0] exc_class,
  output logic [VA_W-1:0]  tec
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK_ROOT, ST_FETCH, ST_WAIT, ST_DECODE, ST_DONE, ST_FAULT
  } st_e;

  st_e               st;
  logic [VA_W-1:0]   va_q, org_q, ra_q;
  logic [ENT_W-1:0]  root_q, ent_q;
  logic [1:0]        acc_q, sid_q;
  logic              large_q, ro_q;
  lvl_e              lvl_q;
  xcls_e             cls_q;

  logic              rc_real;
  lvl_e              rc_lvl;
  xcls_e             rc_cls;
  logic [VA_W-1:0]   rc_org;

  xcls_e             dc_cls;
  logic              dc_leaf, dc_ro;
  lvl_e              dc_nlvl;
  logic [VA_W-1:0]   dc_norg, dc_ra;
  logic              ro_acc;
  logic [IDX_W-1:0]  idx;

  pt_root_check u_root (
    .va(va_q), .root(root_q), .real_sp(rc_real), .top_lvl(rc_lvl),
    .cls(rc_cls), .origin(rc_org)
  );

  pt_entry_decode u_dec (
    .lvl(lvl_q), .ent(ent_q), .va(va_q), .large_en(large_q),
    .cls(dc_cls), .leaf(dc_leaf), .ro(dc_ro), .nxt_lvl(dc_nlvl),
    .nxt_org(dc_norg), .leaf_ra(dc_ra)
  );

  pt_tec_fmt u_tec (
    .va(va_q), .acc(acc_q), .sid(sid_q), .prot(cls_q == XC_PROT), .tec(tec)
  );

  always_comb begin
    case (lvl_q)
      LV_R1:   idx = va_q[63:53];
      LV_R2:   idx = va_q[52:42];
      LV_R3:   idx = va_q[41:31];
      LV_SEG:  idx = va_q[30:20];
      default: idx = {{(IDX_W-PIX_W){1'b0}}, va_q[19:12]};
    endcase
  end

  assign ro_acc        = ro_q | dc_ro;
  assign mem_addr      = org_q + {{(VA_W-OFS_W){1'b0}}, idx, 3'b000};
  assign mem_req_valid = (st == ST_FETCH);
  assign mem_rsp_ready = (st == ST_WAIT);
  assign req_ready     = (st == ST_IDLE);
  assign done          = (st == ST_DONE);
  assign exc           = (st == ST_FAULT);
  assign real_addr     = ra_q;
  assign wr_ok         = ~ro_q;
  assign exc_class     = cls_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      acc_q   <= '0;
      sid_q   <= '0;
      large_q <= 1'b0;
      lvl_q   <= LV_SEG;
      org_q   <= '0;
      ent_q   <= '0;
      ro_q    <= 1'b0;
      ra_q    <= '0;
      cls_q   <= XC_NONE;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_va;
          root_q  <= req_root;
          acc_q   <= req_acc;
          sid_q   <= req_sid;
          large_q <= req_large;
          ro_q    <= 1'b0;
          cls_q   <= XC_NONE;
          st      <= ST_CHECK_ROOT;
        end
        ST_CHECK_ROOT: begin
          if (rc_real) begin
            ra_q <= {va_q[63:12], 12'h0};
            st   <= ST_DONE;
          end else if (rc_cls != XC_NONE) begin
            cls_q <= rc_cls;
            st    <= ST_FAULT;
          end else begin
            lvl_q <= rc_lvl;
            org_q <= rc_org;
            st    <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          ent_q <= mem_rsp_data;
          st    <= ST_DECODE;
        end
        ST_DECODE: begin
          if (dc_cls != XC_NONE) begin
            cls_q <= dc_cls;
            st    <= ST_FAULT;
          end else if (dc_leaf) begin
            ro_q <= ro_acc;
            ra_q <= dc_ra;
            if (acc_q == ACC_STORE && ro_acc) begin
              cls_q <= XC_PROT;
              st    <= ST_FAULT;
            end else begin
              st <= ST_DONE;
            end
          end else begin
            ro_q  <= ro_acc;
            lvl_q <= dc_nlvl;
            org_q <= dc_norg;
            st    <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_addr,
  input logic        mem_rsp_ready,
  input logic        done,
  input logic        exc,
  input logic [3:0]  exc_class,
  input logic [63:0] tec,
  input logic [63:0] real_addr
);
  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_one_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exc));

  assert_single_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  assert_hold_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

  assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_addr[2:0] == 3'b000));

  assert_prot_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (tec[2] == (exc_class == 4'd8)));

  assert_dir_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (tec[11] ^ tec[10]));

  assert_prot_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && exc_class == 4'd8) |-> tec[10]);

  assert_ra_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (real_addr[11:0] == 12'h0));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_addr(mem_addr), .mem_rsp_ready(mem_rsp_ready), .done(done), .exc(exc),
  .exc_class(exc_class), .tec(tec), .real_addr(real_addr)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic [63:0] req_root = '0;
  logic [1:0]  req_sid = '0;
  logic        req_large = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data;
  logic        done, wr_ok, exc;
  logic [63:0] real_addr, tec;
  logic [3:0]  exc_class;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_acc(req_acc), .req_root(req_root), .req_sid(req_sid),
    .req_large(req_large), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .done(done), .real_addr(real_addr),
    .wr_ok(wr_ok), .exc(exc), .exc_class(exc_class), .tec(tec)
  );

  logic [63:0] mem [logic [63:0]];
  logic [63:0] ent_addr [5];

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [3:0] tcls(input int lv);
    case (lv)
      3: return 4'd2;
      2: return 4'd3;
      1: return 4'd4;
      default: return 4'd5;
    endcase
  endfunction

  function automatic logic [1:0] top2b(input logic [63:0] va, input int lv);
    case (lv)
      3: return va[63:62];
      2: return va[52:51];
      1: return va[41:40];
      default: return va[30:29];
    endcase
  endfunction

  function automatic logic [63:0] idxb(input logic [63:0] va, input int lv);
    case (lv)
      3: return {53'h0, va[63:53]};
      2: return {53'h0, va[52:42]};
      1: return {53'h0, va[41:31]};
      0: return {53'h0, va[30:20]};
      default: return {56'h0, va[19:12]};
    endcase
  endfunction

  // Reference walk written from the requirements
  function automatic void ref_walk(input logic [63:0] va, input logic [1:0] acc,
      input logic [63:0] root, input logic [1:0] sid, input bit lg,
      output bit ok, output bit ro, output logic [63:0] ra,
      output logic [3:0] cls, output logic [63:0] et);
    int lv;
    logic [63:0] org, e;
    bit leaf;
    logic [1:0] t2;
    ro = 0; ra = '0; cls = '0; leaf = 0; org = '0; lv = 0;
    if (root[5]) begin
      ra = {va[63:12], 12'h0};
    end else begin
      lv = int'(root[3:2]);
      if ((lv == 2 && va[63:53] != 0) || (lv == 1 && va[63:42] != 0) ||
          (lv == 0 && va[63:31] != 0))
        cls = 4'd1;
      else if (top2b(va, lv) > root[1:0])
        cls = tcls(lv);
      org = {root[63:12], 12'h0};
      while (cls == 0 && !leaf) begin
        e = rd(org + (idxb(va, lv) << 3));
        if (lv == 4) begin
          if (e[10]) cls = 4'd6;
          else if (e[11]) cls = 4'd7;
          else begin
            if (e[9]) ro = 1;
            ra = {e[63:12], 12'h0};
            leaf = 1;
          end
        end else if (e[5]) cls = tcls(lv);
        else if (int'(e[3:2]) != lv) cls = 4'd7;
        else if (lv == 0) begin
          if (e[9]) ro = 1;
          if (e[10] && lg) begin
            ra = {e[63:20], va[19:12], 12'h0};
            leaf = 1;
          end else begin
            org = {e[63:11], 11'h0};
            lv = 4;
          end
        end else begin
          t2 = top2b(va, lv - 1);
          if (t2 < e[7:6] || t2 > e[1:0]) cls = tcls(lv - 1);
          else begin
            if (lg && e[9]) ro = 1;
            org = {e[63:12], 12'h0};
            lv = lv - 1;
          end
        end
      end
    end
    ok = (cls == 0);
    if (ok && acc == 2'd1 && ro) begin ok = 0; cls = 4'd8; end
    et = {va[63:12], 12'h0} | ((acc == 2'd1) ? 64'h400 : 64'h800) |
         ((cls == 4'd8) ? 64'h4 : 64'h0) | {62'h0, sid};
  endfunction

  // Memory model: random request stalls, 0-2 cycle response delay
  bit pend;
  int dly;
  int rd_cnt;
  logic [63:0] raddr;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend <= 0; dly <= 0; rd_cnt <= 0; raddr <= '0;
    end else if (!pend) begin
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1; raddr <= mem_addr; dly <= int'($urandom % 3);
        rd_cnt <= rd_cnt + 1; mem_req_ready <= 1'b0;
      end else begin
        mem_req_ready <= ($urandom % 3) != 0;
      end
    end else if (!mem_rsp_valid) begin
      if (dly == 0) begin
        mem_rsp_valid <= 1'b1; mem_rsp_data <= rd(raddr);
      end else dly <= dly - 1;
    end else if (mem_rsp_ready) begin
      mem_rsp_valid <= 1'b0; pend <= 0;
    end
  end

  task automatic chk(input bit cond, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic make_case(input int tsel, input bit clean,
                           output logic [63:0] va, output logic [63:0] root);
    int t;
    logic [63:0] cur, nxt, e;
    mem.delete();
    t = (tsel < 0) ? int'($urandom % 4) : tsel;
    va = {$urandom, $urandom};
    if (clean || ($urandom % 8) != 0)
      case (t)
        2: va[63:53] = '0;
        1: va[63:42] = '0;
        0: va[63:31] = '0;
        default: ;
      endcase
    root = 64'h10000 | (64'(t) << 2) |
           ((clean || ($urandom % 6) != 0) ? 64'h3 : 64'($urandom % 3));
    cur = 64'h10000;
    for (int lv = t; lv >= 1; lv--) begin
      nxt = 64'h100000 * 64'(lv + 1);
      e = nxt | (64'(lv) << 2) | 64'h3;
      if (!clean) begin
        if ($urandom % 8 == 0) e[7:6] = 2'($urandom % 4);
        if ($urandom % 8 == 0) e[1:0] = 2'($urandom % 4);
        if ($urandom % 16 == 0) e[5] = 1'b1;
        if ($urandom % 16 == 0) e[2] = ~e[2];
        if ($urandom % 4 == 0) e[9] = 1'b1;
      end
      ent_addr[lv] = cur + (idxb(va, lv) << 3);
      mem[ent_addr[lv]] = e;
      cur = nxt;
    end
    ent_addr[0] = cur + (idxb(va, 0) << 3);
    if (!clean && $urandom % 4 == 0)
      e = ({$urandom, $urandom} & ~64'hFFFFF) | 64'h400;
    else
      e = 64'h900800;
    if (!clean) begin
      if ($urandom % 16 == 0) e[5] = 1'b1;
      if ($urandom % 16 == 0) e[2] = ~e[2];
      if ($urandom % 4 == 0) e[9] = 1'b1;
    end
    mem[ent_addr[0]] = e;
    ent_addr[4] = 64'h900800 + (idxb(va, 4) << 3);
    e = {$urandom, $urandom} & ~64'hFFF;
    if (!clean) begin
      if ($urandom % 4 == 0) e[9] = 1'b1;
      if ($urandom % 16 == 0) e[10] = 1'b1;
      if ($urandom % 16 == 0) e[11] = 1'b1;
    end
    mem[ent_addr[4]] = e;
  endtask

  task automatic run(input logic [63:0] va, input logic [1:0] acc,
                     input logic [63:0] root, input logic [1:0] sid,
                     input bit lg, input string tag, output int reads);
    bit eok, ero;
    logic [63:0] era, et;
    logic [3:0] ecls;
    int n, c0;
    ref_walk(va, acc, root, sid, lg, eok, ero, era, ecls, et);
    @(negedge clk);
    req_va = va; req_acc = acc; req_root = root; req_sid = sid; req_large = lg;
    req_valid = 1'b1;
    c0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "req_ready while busy", 64'(req_ready), 64'h0);
    n = 0;
    while (!(done || exc) && n < 400) begin @(negedge clk); n++; end
    chk(n < 400, tag, "walk timeout", 64'(n), 64'h0);
    reads = rd_cnt - c0;
    chk(exc == !eok && done == eok, tag, "done/exc", {62'h0, done, exc},
        {62'h0, eok, !eok});
    if (eok) begin
      chk(real_addr == era, tag, "real_addr", real_addr, era);
      chk(wr_ok == !ero, "R10", "wr_ok", 64'(wr_ok), 64'(!ero));
    end else begin
      chk(exc_class == ecls, tag, "exc_class", 64'(exc_class), 64'(ecls));
      chk(tec == et, "R11", "tec", tec, et);
    end
  endtask

  function automatic string tag_of(input logic [63:0] va, input logic [1:0] acc,
      input logic [63:0] root, input logic [1:0] sid, input bit lg);
    bit ok, ro; logic [63:0] ra, et; logic [3:0] c;
    ref_walk(va, acc, root, sid, lg, ok, ro, ra, c, et);
    case (c)
      4'd0: return root[5] ? "R2" : "R5";
      4'd1: return "R3";
      4'd6: return "R9";
      4'd7: return "R6";
      4'd8: return "R10";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] va, root;
    int rdn;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !exc && !mem_req_valid, "R1", "reset state",
        {60'h0, req_ready, done, exc, mem_req_valid}, 64'h8);

    // R2: real-space root, no reads
    make_case(3, 1, va, root);
    run(64'hDEAD_BEEF_1234_5678, 2'd0, 64'hFFFF_0000_0000_002C, 2'd2, 0, "R2", rdn);
    chk(rdn == 0, "R2", "reads", 64'(rdn), 64'h0);

    // R3: segment root with va above 2 GB
    make_case(0, 1, va, root);
    va[40] = 1'b1;
    run(va, 2'd1, root, 2'd1, 0, "R3", rdn);

    // R4: region-first length too small
    make_case(3, 1, va, root);
    va[63:62] = 2'd2; root[1:0] = 2'd1;
    run(va, 2'd0, root, 2'd3, 0, "R4", rdn);
    chk(rdn == 0, "R4", "reads", 64'(rdn), 64'h0);

    // R5: full five-level walk
    make_case(3, 1, va, root);
    run(va, 2'd2, root, 2'd0, 0, "R5", rdn);
    chk(rdn == 5, "R5", "reads", 64'(rdn), 64'h5);

    // R6: invalid region-second entry, then type mismatch on segment
    make_case(2, 1, va, root);
    mem[ent_addr[2]] = mem[ent_addr[2]] | 64'h20;
    run(va, 2'd0, root, 2'd0, 0, "R6", rdn);
    make_case(1, 1, va, root);
    mem[ent_addr[0]] = mem[ent_addr[0]] ^ 64'h4;
    run(va, 2'd0, root, 2'd0, 0, "R6", rdn);

    // R7: region-first offset above next index bits
    make_case(3, 1, va, root);
    va[52:51] = 2'd0;
    mem[ent_addr[3]] = mem[ent_addr[3]] | 64'hC0;
    run(va, 2'd0, root, 2'd0, 0, "R7", rdn);

    // R8: large page with and without enable
    make_case(0, 1, va, root);
    mem[ent_addr[0]] = 64'hABCD_E000_0030_0400;
    run(va, 2'd0, root, 2'd0, 1, "R8", rdn);
    chk(rdn == 1, "R8", "reads large", 64'(rdn), 64'h1);
    run(va, 2'd0, root, 2'd0, 0, "R8", rdn);
    chk(rdn == 2, "R8", "reads disabled", 64'(rdn), 64'h2);

    // R9: page invalid, then page reserved bit
    make_case(0, 1, va, root);
    mem[ent_addr[4]] = mem[ent_addr[4]] | 64'h400;
    run(va, 2'd0, root, 2'd0, 0, "R9", rdn);
    make_case(0, 1, va, root);
    mem[ent_addr[4]] = mem[ent_addr[4]] | 64'h800;
    run(va, 2'd0, root, 2'd0, 0, "R9", rdn);

    // R10: read-only page store; region read-only with/without large enable
    make_case(1, 1, va, root);
    mem[ent_addr[4]] = mem[ent_addr[4]] | 64'h200;
    run(va, 2'd1, root, 2'd3, 0, "R10", rdn);
    make_case(1, 1, va, root);
    mem[ent_addr[1]] = mem[ent_addr[1]] | 64'h200;
    run(va, 2'd1, root, 2'd1, 0, "R10", rdn);
    run(va, 2'd1, root, 2'd1, 1, "R10", rdn);

    // Random mix; stalls on the read port exercise R12
    for (int i = 0; i < 300; i++) begin
      logic [1:0] acc, sid;
      bit lg;
      make_case(-1, 0, va, root);
      acc = 2'($urandom % 3);
      sid = 2'($urandom % 4);
      lg  = ($urandom % 2) != 0;
      run(va, acc, root, sid, lg, tag_of(va, acc, root, sid, lg), rdn);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule